// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs a single access on an external asynchronous memory bus for one chip-select. A start pulse, with a flag that selects a read or a write, launches a cycle. From then on an internal tick counter steps once per functional clock. The chip-select, address-valid, output-enable and write-enable strobes are all active low. Each one falls and rises at tick counts taken from five packed configuration words.

For a read, the block also raises a one-clock capture strobe at the tick when read data is to be sampled. When the counter reaches the cycle length for the current direction, a one-clock done pulse marks the end of the cycle. The only synchronous feature is an output-clock enable. It marks each rising edge of a divided bus clock while the selected direction is set to synchronous.

The configuration is captured when the cycle starts. Software may therefore rewrite the words while a cycle is running without disturbing it.

Top module: `asmem_strobe_seq`

## Requirements
- R1: After reset and whenever no cycle is running, all four strobes are high and capture_o, done_o and bus_clk_en_o are low.
- R2: A start_i seen at a clock edge while idle captures write_i and all five configuration words. The cycle that follows that edge is tick 0, and the tick advances by one every clock until the end. Configuration changes after the start have no effect on that cycle.
- R3: Chip-select uses cfg_cs_i and address-valid uses cfg_adv_i, both with the same layout: assert tick in bits 3:0, read deassert tick in bits 12:8, write deassert tick in bits 20:16. The strobe is low exactly on ticks t with on <= t < off, where off is taken for the current direction. If off <= on, the strobe stays high for the whole cycle.
- R4: In cfg_rw_i, output-enable asserts at bits 3:0 and deasserts at bits 12:8, and it is driven only on reads. Write-enable asserts at bits 19:16 and deasserts at bits 28:24, and it is driven only on writes. Both follow the window rule of R3.
- R5: In cfg_len_i, bits 4:0 give the read length L and bits 12:8 give the write length. done_o is high for exactly one clock, at tick L, and all strobes are high in that clock. A length of 0 ends the cycle at tick 0.
- R6: On reads, capture_o is high for one clock at the tick given by cfg_len_i bits 20:16, provided that tick is below L. It never fires on writes.
- R7: A start_i that arrives while a cycle is running, including the done clock, is ignored.
- R8: In cfg_mode_i, bits 1:0 hold the divider minus one (divider 1 to 4). Bit 8 makes reads synchronous and bit 9 makes writes synchronous. When the bit for the current direction is set, bus_clk_en_o is high on every tick t < L with t mod divider = 0. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch request, one clock |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| cfg_mode_i | input | 32 | Divider and synchronous-type word |
| cfg_cs_i | input | 32 | Chip-select edge word |
| cfg_adv_i | input | 32 | Address-valid edge word |
| cfg_rw_i | input | 32 | Output-enable and write-enable edge word |
| cfg_len_i | input | 32 | Cycle lengths and data access tick |
| cs_n_o | output | 1 | Chip-select, active low |
| adv_n_o | output | 1 | Address-valid, active low |
| oe_n_o | output | 1 | Output-enable, active low |
| we_n_o | output | 1 | Write-enable, active low |
| capture_o | output | 1 | Read data sample strobe |
| done_o | output | 1 | End-of-cycle pulse |
| bus_clk_en_o | output | 1 | Divided bus clock rising-edge marker |

## Verification
The assertions assume that start_i and write_i are synchronous to clk. They also assume the configuration words are stable at the edge that launches a cycle. Nothing is assumed about the words during a cycle, and the stimulus deliberately changes them mid-cycle and issues extra starts while a cycle is running.

The stimulus changes inputs only at falling edges. The settings include all-zero fields, the 5-bit maximum of 31, deassert ticks at or before the assert tick, access ticks at or beyond the cycle length, every divider value, and raw random words.

// File: rtl/asmem_seq_pkg.sv
package asmem_seq_pkg;
  localparam int unsigned TICK_W = 5;
  localparam int unsigned ON_W   = 4;
  localparam int unsigned DIV_W  = 2;

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [ON_W-1:0]   on_t;

  typedef struct packed {
    on_t   on;
    tick_t off_rd;
    tick_t off_wr;
  } edge_pair_t;

  typedef struct packed {
    edge_pair_t       cs;
    edge_pair_t       adv;
    on_t              oe_on;
    tick_t            oe_off;
    on_t              we_on;
    tick_t            we_off;
    tick_t            len_rd;
    tick_t            len_wr;
    tick_t            acc;
    logic [DIV_W-1:0] div_m1;
    logic             sync_rd;
    logic             sync_wr;
  } seq_cfg_t;

  // Strobe window: active on ticks on..off-1, empty when off <= on.
  function automatic logic in_window(tick_t t, on_t on, tick_t off);
    tick_t on_x;
    on_x = tick_t'(on);
    return (off > on_x) && (t >= on_x) && (t < off);
  endfunction

  // Rising edge of the divided clock: tick is a multiple of div_m1+1.
  function automatic logic div_phase_hit(tick_t t, logic [DIV_W-1:0] div_m1);
    logic hit;
    case (div_m1)
      2'd0:    hit = 1'b1;
      2'd1:    hit = ~t[0];
      2'd2:    hit = ((t % tick_t'(3)) == '0);
      default: hit = (t[1:0] == 2'b00);
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/asmem_tick_ctr.sv
module asmem_tick_ctr
  import asmem_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  tick_t len,
  output logic  active,
  output tick_t tick,
  output logic  at_end,
  output logic  launch
);
  assign launch = start && !active;
  assign at_end = active && (tick == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick   <= '0;
    end else if (launch) begin
      active <= 1'b1;
      tick   <= '0;
    end else if (at_end) begin
      active <= 1'b0;
      tick   <= '0;
    end else if (active) begin
      tick <= tick + tick_t'(1);
    end
  end
endmodule

// File: rtl/asmem_strobe_win.sv
module asmem_strobe_win
  import asmem_seq_pkg::*;
(
  input  logic  active,
  input  logic  at_end,
  input  logic  allow,
  input  tick_t tick,
  input  on_t   on,
  input  tick_t off,
  output logic  strobe_n
);
  logic live;
  assign live     = active && !at_end && allow;
  assign strobe_n = !(live && in_window(tick, on, off));
endmodule

// File: rtl/asmem_clk_en.sv
module asmem_clk_en
  import asmem_seq_pkg::*;
(
  input  logic             active,
  input  logic             at_end,
  input  logic             sync_sel,
  input  logic [DIV_W-1:0] div_m1,
  input  tick_t            tick,
  output logic             clk_en
);
  assign clk_en = active && !at_end && sync_sel && div_phase_hit(tick, div_m1);
endmodule

// File: rtl/asmem_strobe_seq.sv
module asmem_strobe_seq
  import asmem_seq_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [CFG_W-1:0] cfg_mode_i,
  input  logic [CFG_W-1:0] cfg_cs_i,
  input  logic [CFG_W-1:0] cfg_adv_i,
  input  logic [CFG_W-1:0] cfg_rw_i,
  input  logic [CFG_W-1:0] cfg_len_i,
  output logic             cs_n_o,
  output logic             adv_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             capture_o,
  output logic             done_o,
  output logic             bus_clk_en_o
);
  // Field positions that software and this block agree on.
  localparam int unsigned ON_LSB    = 0;
  localparam int unsigned RDOFF_LSB = 8;
  localparam int unsigned WROFF_LSB = 16;
  localparam int unsigned WEON_LSB  = 16;
  localparam int unsigned WEOFF_LSB = 24;
  localparam int unsigned LENR_LSB  = 0;
  localparam int unsigned LENW_LSB  = 8;
  localparam int unsigned ACC_LSB   = 16;
  localparam int unsigned DIV_LSB   = 0;
  localparam int unsigned SYNR_BIT  = 8;
  localparam int unsigned SYNW_BIT  = 9;
  localparam int unsigned N_STROBE  = 4;

  seq_cfg_t cfg_d, cfg_q;
  logic     wr_q;

  function automatic edge_pair_t split_edges(logic [CFG_W-1:0] w);
    edge_pair_t e;
    e.on     = w[ON_LSB    +: ON_W];
    e.off_rd = w[RDOFF_LSB +: TICK_W];
    e.off_wr = w[WROFF_LSB +: TICK_W];
    return e;
  endfunction

  always_comb begin
    cfg_d.cs      = split_edges(cfg_cs_i);
    cfg_d.adv     = split_edges(cfg_adv_i);
    cfg_d.oe_on   = cfg_rw_i[ON_LSB    +: ON_W];
    cfg_d.oe_off  = cfg_rw_i[RDOFF_LSB +: TICK_W];
    cfg_d.we_on   = cfg_rw_i[WEON_LSB  +: ON_W];
    cfg_d.we_off  = cfg_rw_i[WEOFF_LSB +: TICK_W];
    cfg_d.len_rd  = cfg_len_i[LENR_LSB +: TICK_W];
    cfg_d.len_wr  = cfg_len_i[LENW_LSB +: TICK_W];
    cfg_d.acc     = cfg_len_i[ACC_LSB  +: TICK_W];
    cfg_d.div_m1  = cfg_mode_i[DIV_LSB +: DIV_W];
    cfg_d.sync_rd = cfg_mode_i[SYNR_BIT];
    cfg_d.sync_wr = cfg_mode_i[SYNW_BIT];
  end

  // Bits of the words that carry no field for this block.
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_mode_i[CFG_W-1:SYNW_BIT+1], cfg_mode_i[SYNR_BIT-1:DIV_W],
                             cfg_cs_i[CFG_W-1:WROFF_LSB+TICK_W], cfg_cs_i[WROFF_LSB-1:RDOFF_LSB+TICK_W],
                             cfg_cs_i[RDOFF_LSB-1:ON_W],
                             cfg_adv_i[CFG_W-1:WROFF_LSB+TICK_W], cfg_adv_i[WROFF_LSB-1:RDOFF_LSB+TICK_W],
                             cfg_adv_i[RDOFF_LSB-1:ON_W],
                             cfg_rw_i[CFG_W-1:WEOFF_LSB+TICK_W], cfg_rw_i[WEOFF_LSB-1:WEON_LSB+ON_W],
                             cfg_rw_i[WEON_LSB-1:RDOFF_LSB+TICK_W], cfg_rw_i[RDOFF_LSB-1:ON_W],
                             cfg_len_i[CFG_W-1:ACC_LSB+TICK_W], cfg_len_i[ACC_LSB-1:LENW_LSB+TICK_W],
                             cfg_len_i[LENW_LSB-1:TICK_W]};

  // Named internal events, used by the bound checker.
  logic  cycle_active;
  logic  cycle_end;
  logic  cycle_launch;
  tick_t tick;
  tick_t len_sel;

  assign len_sel = wr_q ? cfg_q.len_wr : cfg_q.len_rd;

  asmem_tick_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .len    (len_sel),
    .active (cycle_active),
    .tick   (tick),
    .at_end (cycle_end),
    .launch (cycle_launch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wr_q  <= 1'b0;
    end else if (cycle_launch) begin
      cfg_q <= cfg_d;
      wr_q  <= write_i;
    end
  end

  // Per-strobe edge selection: index 0 cs, 1 adv, 2 oe, 3 we.
  on_t   on_v    [N_STROBE];
  tick_t off_v   [N_STROBE];
  logic  allow_v [N_STROBE];
  logic  [N_STROBE-1:0] strobe_n_v;

  always_comb begin
    on_v[0]    = cfg_q.cs.on;
    off_v[0]   = wr_q ? cfg_q.cs.off_wr : cfg_q.cs.off_rd;
    allow_v[0] = 1'b1;
    on_v[1]    = cfg_q.adv.on;
    off_v[1]   = wr_q ? cfg_q.adv.off_wr : cfg_q.adv.off_rd;
    allow_v[1] = 1'b1;
    on_v[2]    = cfg_q.oe_on;
    off_v[2]   = cfg_q.oe_off;
    allow_v[2] = !wr_q;
    on_v[3]    = cfg_q.we_on;
    off_v[3]   = cfg_q.we_off;
    allow_v[3] = wr_q;
  end

  for (genvar gi = 0; gi < N_STROBE; gi++) begin : g_strobe
    asmem_strobe_win u_win (
      .active   (cycle_active),
      .at_end   (cycle_end),
      .allow    (allow_v[gi]),
      .tick     (tick),
      .on       (on_v[gi]),
      .off      (off_v[gi]),
      .strobe_n (strobe_n_v[gi])
    );
  end

  assign cs_n_o  = strobe_n_v[0];
  assign adv_n_o = strobe_n_v[1];
  assign oe_n_o  = strobe_n_v[2];
  assign we_n_o  = strobe_n_v[3];

  asmem_clk_en u_clken (
    .active   (cycle_active),
    .at_end   (cycle_end),
    .sync_sel (wr_q ? cfg_q.sync_wr : cfg_q.sync_rd),
    .div_m1   (cfg_q.div_m1),
    .tick     (tick),
    .clk_en   (bus_clk_en_o)
  );

  assign capture_o = cycle_active && !cycle_end && !wr_q && (tick == cfg_q.acc);
  assign done_o    = cycle_end;
endmodule

// File: rtl/asmem_strobe_seq_chk.sv
module asmem_strobe_seq_chk
  import asmem_seq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  start_i,
  input logic  cycle_active,
  input logic  wr_q,
  input tick_t tick,
  input logic  cs_n_o,
  input logic  adv_n_o,
  input logic  oe_n_o,
  input logic  we_n_o,
  input logic  capture_o,
  input logic  done_o,
  input logic  bus_clk_en_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_active |-> (cs_n_o && adv_n_o && oe_n_o && we_n_o && !capture_o && !done_o && !bus_clk_en_o));

  assert_launch_tick0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cycle_active) |=> (cycle_active && tick == '0));

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_active && !done_o) |=> (cycle_active && tick == $past(tick) + tick_t'(1)));

  assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> !wr_q);

  assert_we_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> wr_q);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && adv_n_o && oe_n_o && we_n_o && !bus_clk_en_o));

  assert_capture_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> (!wr_q && !done_o));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_active |=> $stable(wr_q));
endmodule

bind asmem_strobe_seq asmem_strobe_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cycle_active (cycle_active),
  .wr_q         (wr_q),
  .tick         (tick),
  .cs_n_o       (cs_n_o),
  .adv_n_o      (adv_n_o),
  .oe_n_o       (oe_n_o),
  .we_n_o       (we_n_o),
  .capture_o    (capture_o),
  .done_o       (done_o),
  .bus_clk_en_o (bus_clk_en_o)
);

// File: tb/asmem_strobe_seq_tb_top.sv
module asmem_strobe_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic write_i = 1'b0;
  logic [31:0] cfg_mode_i = '0, cfg_cs_i = '0, cfg_adv_i = '0, cfg_rw_i = '0, cfg_len_i = '0;
  logic cs_n_o, adv_n_o, oe_n_o, we_n_o, capture_o, done_o, bus_clk_en_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  asmem_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .cfg_mode_i(cfg_mode_i), .cfg_cs_i(cfg_cs_i), .cfg_adv_i(cfg_adv_i),
    .cfg_rw_i(cfg_rw_i), .cfg_len_i(cfg_len_i),
    .cs_n_o(cs_n_o), .adv_n_o(adv_n_o), .oe_n_o(oe_n_o), .we_n_o(we_n_o),
    .capture_o(capture_o), .done_o(done_o), .bus_clk_en_o(bus_clk_en_o)
  );

  typedef struct packed {
    logic cs, adv, oe, we, cap, done, clken;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   finished = 1'b0;
  string scen = "reset";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s [%s] actual=%0d expected=%0d at %0t", req, what, scen, act, exp, $time);
    end
  endtask

  // Reference model: strobe low on ticks in [on, off) when off exceeds on.
  function automatic bit low_at(int t, int on, int off);
    if (off <= on) return 1'b0;
    return (t >= on) && (t < off);
  endfunction

  // Monitor: compares each output against the scoreboard, or the idle state.
  always @(negedge clk) begin
    if (!finished) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cs_n_o == e.cs,   "R3", "cs_n",  cs_n_o,  e.cs);
        chk(adv_n_o == e.adv, "R3", "adv_n", adv_n_o, e.adv);
        chk(oe_n_o == e.oe,   "R4", "oe_n",  oe_n_o,  e.oe);
        chk(we_n_o == e.we,   "R4", "we_n",  we_n_o,  e.we);
        chk(capture_o == e.cap, "R6", "capture", capture_o, e.cap);
        chk(done_o == e.done,   "R5", "done",    done_o,    e.done);
        chk(bus_clk_en_o == e.clken, "R8", "clk_en", bus_clk_en_o, e.clken);
      end else begin
        chk({cs_n_o, adv_n_o, oe_n_o, we_n_o, capture_o, done_o, bus_clk_en_o} == 7'b1111000,
            "R1", "idle outputs",
            int'({cs_n_o, adv_n_o, oe_n_o, we_n_o, capture_o, done_o, bus_clk_en_o}), 7'b1111000);
      end
    end
  end

  // Driver: starts one cycle, pushes the expected waveform, optionally disturbs inputs (R2, R7).
  task automatic run_cycle(input bit wr, input logic [31:0] wm, input logic [31:0] wc,
                           input logic [31:0] wa, input logic [31:0] wr_w, input logic [31:0] wl,
                           input string tag, input bit poke);
    int len, acc, div, sync;
    int cs_on, cs_off, ad_on, ad_off, oe_on, oe_off, we_on, we_off;
    @(negedge clk);
    scen = tag;
    write_i = wr; cfg_mode_i = wm; cfg_cs_i = wc; cfg_adv_i = wa; cfg_rw_i = wr_w; cfg_len_i = wl;
    start_i = 1'b1;
    len    = wr ? int'((wl >> 8) & 32'h1f) : int'(wl & 32'h1f);
    acc    = int'((wl >> 16) & 32'h1f);
    div    = int'(wm & 32'h3) + 1;
    sync   = wr ? int'((wm >> 9) & 1) : int'((wm >> 8) & 1);
    cs_on  = int'(wc & 32'hf);
    cs_off = wr ? int'((wc >> 16) & 32'h1f) : int'((wc >> 8) & 32'h1f);
    ad_on  = int'(wa & 32'hf);
    ad_off = wr ? int'((wa >> 16) & 32'h1f) : int'((wa >> 8) & 32'h1f);
    oe_on  = int'(wr_w & 32'hf);
    oe_off = int'((wr_w >> 8) & 32'h1f);
    we_on  = int'((wr_w >> 16) & 32'hf);
    we_off = int'((wr_w >> 24) & 32'h1f);
    @(posedge clk);
    #1;
    for (int t = 0; t <= len; t++) begin
      exp_t e;
      bit fin;
      fin = (t == len);
      e.cs    = fin || !low_at(t, cs_on, cs_off);
      e.adv   = fin || !low_at(t, ad_on, ad_off);
      e.oe    = fin || wr || !low_at(t, oe_on, oe_off);
      e.we    = fin || !wr || !low_at(t, we_on, we_off);
      e.cap   = !fin && !wr && (t == acc);
      e.done  = fin;
      e.clken = !fin && (sync != 0) && ((t % div) == 0);
      exp_q.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R7: extra start mid-cycle with flipped direction; R2: words rewritten mid-cycle.
      start_i = 1'b1; write_i = !wr;
      cfg_cs_i = ~wc; cfg_adv_i = ~wa; cfg_rw_i = ~wr_w; cfg_len_i = ~wl; cfg_mode_i = ~wm;
      @(negedge clk);
      start_i = 1'b0;
      while (exp_q.size() > 1) @(negedge clk);
      // R7: start during the done clock is also ignored.
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] edges(int on, int rd_off, int wr_off);
    return (32'(wr_off) << 16) | (32'(rd_off) << 8) | 32'(on);
  endfunction

  function automatic logic [31:0] rw_word(int oe_on, int oe_off, int we_on, int we_off);
    return (32'(we_off) << 24) | (32'(we_on) << 16) | (32'(oe_off) << 8) | 32'(oe_on);
  endfunction

  function automatic logic [31:0] len_word(int rd, int wr, int acc);
    return (32'(acc) << 16) | (32'(wr) << 8) | 32'(rd);
  endfunction

  function automatic logic [31:0] mode_word(int div, bit srd, bit swr);
    return (32'(swr) << 9) | (32'(srd) << 8) | 32'(div - 1);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R6: plain asynchronous read
    run_cycle(1'b0, mode_word(1, 0, 0), edges(2, 12, 6), edges(0, 3, 2),
              rw_word(4, 11, 1, 5), len_word(14, 9, 10), "R3 read basic", 1'b0);
    // R3 R4: plain write, different length and deassert ticks
    run_cycle(1'b1, mode_word(1, 0, 0), edges(2, 12, 15), edges(1, 3, 4),
              rw_word(4, 11, 3, 13), len_word(14, 16, 10), "R4 write basic", 1'b0);
    // R5: all fields zero, cycle ends at tick 0
    run_cycle(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R5 zero fields", 1'b0);
    run_cycle(1'b1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R5 zero write", 1'b0);
    // R5 R6 R8: maximum values, access at length -> no capture, divider 4
    run_cycle(1'b0, mode_word(4, 1, 0), edges(15, 31, 31), edges(15, 31, 0),
              rw_word(15, 31, 15, 31), len_word(31, 31, 31), "R5 max read", 1'b0);
    run_cycle(1'b1, mode_word(4, 1, 1), edges(15, 31, 31), edges(0, 0, 31),
              rw_word(0, 31, 15, 31), len_word(31, 31, 31), "R8 max write", 1'b0);
    // R3: off equal to / below on, write synchronous divider 3
    run_cycle(1'b1, mode_word(3, 0, 1), edges(9, 20, 9), edges(7, 10, 3),
              rw_word(2, 8, 6, 6), len_word(12, 18, 4), "R3 empty windows", 1'b0);
    // R8: sync bit of the other direction has no effect
    run_cycle(1'b0, mode_word(2, 0, 1), edges(1, 8, 2), edges(0, 2, 2),
              rw_word(3, 9, 0, 4), len_word(10, 3, 5), "R8 other sync", 1'b0);
    // R2 R7: mid-cycle start and config rewrite are ignored, divider 2
    run_cycle(1'b0, mode_word(2, 1, 0), edges(1, 9, 4), edges(0, 2, 1),
              rw_word(3, 8, 2, 6), len_word(11, 7, 6), "R7 busy read", 1'b1);
    run_cycle(1'b1, mode_word(1, 0, 1), edges(0, 3, 5), edges(0, 1, 2),
              rw_word(1, 2, 1, 4), len_word(9, 5, 2), "R2 busy write", 1'b1);
    // R2: random words, both directions
    for (int k = 0; k < 40; k++) begin
      run_cycle(1'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom, "R2 random", k[2]);
    end

    // R1: reset in idle leaves outputs quiet
    scen = "R1 reset";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired [%s]", scen);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule